// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two timer/counter channels for a small microcontroller core. Each channel keeps a high and a low count byte. Each channel counts one of two event sources. The first is a machine-cycle tick, which is the core clock divided by `TICK_DIV`. The second is a falling edge on the channel's external count pin, sampled once per tick. A gate option makes counting also depend on a level pin, which lets software measure the width of a pulse on that pin.

A configuration byte gives each channel one of four counting structures:
- a 13-bit count with a divide-by-32 prescaler;
- a plain 16-bit count;
- an 8-bit count that reloads from the high byte;
- a split mode, selected on channel 0, that makes two independent 8-bit timers.

In split mode the second 8-bit timer borrows channel 1's run bit and overflow flag. Software reaches the configuration byte, the control byte and the four count bytes through a simple register port. The overflow flags are also driven out as level outputs. Every channel 1 overflow produces a one-cycle pulse that can clock a serial baud generator.

Top module: `twin_timer_unit`

## Requirements
- R1: After reset, all six registers (config at select 0, control at 1, ch0 low/high at 2/3, ch1 low/high at 4/5) read 0x00, both overflow flags are 0 and the baud pulse is low.
- R2: A channel with its config nibble (bits 3..0 for ch0, 7..4 for ch1; from high bit to low: gate, source, mode[1:0]) set with source 0 adds exactly one count per TICK_DIV clock edges while its run bit (control bit 0 for ch0, bit 1 for ch1) is 1, and it holds its count while the run bit is 0.
- R3: With source 1, a channel counts one event each time a tick samples its count pin low and the previous tick sample was high. A pulse that stays high for two ticks and then low for two ticks counts once.
- R4: With gate 1, a running channel counts only while its gate pin is high.
- R5: Mode 00 counts in the low five bits of the low byte. Each carry from those bits increments the high byte, and the low byte's upper three bits are kept. The wrap after 0xFF/0x1F sets the channel's overflow flag.
- R6: Mode 01 is a 16-bit count. It wraps from 0xFFFF to 0x0000 and sets the channel's flag (ch0 flag is control bit 2, ch1 flag is control bit 3).
- R7: Mode 10 counts in the low byte only. When the low byte passes 0xFF, it is loaded from the high byte, the high byte is unchanged, and the flag is set.
- R8: Mode 11 on ch0 splits it into two parts. The low byte is an 8-bit counter under ch0's run, gate, source and flag. The high byte counts ticks while ch1's run bit is 1 and sets ch1's flag when it wraps.
- R9: Mode 11 on ch1 freezes both ch1 count bytes, and ch1 then produces no flag and no baud pulse.
- R10: While ch0 is split, ch1 counts in its own mode whatever its run bit is (its gate still applies). It never sets ch1's flag, but each of its wraps still gives a baud pulse.
- R11: Every ch1 wrap raises the baud pulse output for exactly one clock, in the cycle after the wrap.
- R12: Writing 1 to a flag's control bit, or raising that flag's acknowledge input, clears the flag. A hardware set in the same cycle wins over either clear. Writing 0 to a flag bit leaves it unchanged.
- R13: A written register reads back its value. A write to a count byte replaces that byte in that same cycle, and any increment due to that byte in the same cycle is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register written (0 config, 1 control, 2..5 count bytes) |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Register read |
| rd_data | output | 8 | Read data, combinational from rd_sel |
| cnt_pin | input | 2 | External count pins, bit per channel |
| gate_pin | input | 2 | External gate level pins, bit per channel |
| flag_ack | input | 2 | Per-channel overflow flag acknowledge |
| ovf_flag | output | 2 | Overflow flags |
| baud_pulse | output | 1 | One-cycle pulse per channel 1 wrap |

## Verification
Two pairs of functions can fall on the same clock edge.

The first pair is a bus write to a count byte and a tick increment of that byte. The second pair is a hardware overflow set and an acknowledge clear of the same flag. The bench finds the tick phase by polling the running low byte until it changes. It then times a write, and in a later run an acknowledge pulse, onto the edge exactly twelve cycles later.

The write case is judged from the value read back: the written value must appear, not that value plus one. The flag case is judged from the control byte, which must still show the flag set after the collision. A separate acknowledge pulse must then clear it.

// File: rtl/twin_timer_unit.sv
`timescale 1ns/1ps
module twin_timer_unit #(
  parameter int TICK_DIV = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_sel,
  output logic [7:0] rd_data,
  input  logic [1:0] cnt_pin,
  input  logic [1:0] gate_pin,
  input  logic [1:0] flag_ack,
  output logic [1:0] ovf_flag,
  output logic       baud_pulse
);
  localparam int DIV_W = (TICK_DIV < 2) ? 1 : $clog2(TICK_DIV);

  logic [DIV_W-1:0] div_q;
  logic [7:0]       mode_q;
  logic [1:0]       run_q, flag_q, smp_q, fall, ev, set, clr;
  logic [1:0][7:0]  lo_q, hi_q, lo_n, hi_n;
  logic [16:0]      s0, s1;
  logic             tick, split, c1_wrap, baud_q;

  function automatic logic [16:0] step(input logic [1:0] md, input logic [7:0] lo, input logic [7:0] hi);
    logic [16:0] r;
    case (md)
      2'b00:   r = (lo[4:0] == 5'h1f) ? {hi == 8'hff, hi + 8'd1, lo[7:5], 5'd0}
                                      : {1'b0, hi, lo[7:5], lo[4:0] + 5'd1};
      2'b01:   r = {1'b0, hi, lo} + 17'd1;
      2'b10:   r = (lo == 8'hff) ? {1'b1, hi, hi} : {1'b0, hi, lo + 8'd1};
      default: r = {1'b0, hi, lo};
    endcase
    return r;
  endfunction

  assign tick  = (div_q == DIV_W'(TICK_DIV - 1));
  assign fall  = tick ? (smp_q & ~cnt_pin) : 2'b00;
  assign split = (mode_q[1:0] == 2'b11);

  assign ev[0] = run_q[0] & (~mode_q[3] | gate_pin[0]) & (mode_q[2] ? fall[0] : tick);
  assign ev[1] = (run_q[1] | split) & (~mode_q[7] | gate_pin[1]) & (mode_q[6] ? fall[1] : tick);

  assign s0  = step(mode_q[1:0], lo_q[0], hi_q[0]);
  assign s1  = step(mode_q[5:4], lo_q[1], hi_q[1]);
  assign clr = {2{wr_en && wr_sel == 3'd1}} & wr_data[3:2];

  always_comb begin
    lo_n    = lo_q;
    hi_n    = hi_q;
    set     = 2'b00;
    c1_wrap = 1'b0;
    if (ev[0]) begin
      if (split) begin
        lo_n[0] = lo_q[0] + 8'd1;
        set[0]  = &lo_q[0];
      end else begin
        {set[0], hi_n[0], lo_n[0]} = s0;
      end
    end
    if (split && tick && run_q[1]) begin
      hi_n[0] = hi_q[0] + 8'd1;
      set[1]  = &hi_q[0];
    end
    if (ev[1] && mode_q[5:4] != 2'b11) begin
      {c1_wrap, hi_n[1], lo_n[1]} = s1;
      if (!split) set[1] = c1_wrap;
    end
    if (wr_en) begin
      case (wr_sel)
        3'd2:    lo_n[0] = wr_data;
        3'd3:    hi_n[0] = wr_data;
        3'd4:    lo_n[1] = wr_data;
        3'd5:    hi_n[1] = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
      smp_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      baud_q <= 1'b0;
    end else begin
      div_q  <= tick ? '0 : div_q + DIV_W'(1);
      smp_q  <= tick ? cnt_pin : smp_q;
      if (wr_en && wr_sel == 3'd0) mode_q <= wr_data;
      if (wr_en && wr_sel == 3'd1) run_q  <= wr_data[1:0];
      flag_q <= set | (flag_q & ~flag_ack & ~clr);
      lo_q   <= lo_n;
      hi_q   <= hi_n;
      baud_q <= c1_wrap;
    end
  end

  always_comb begin
    case (rd_sel)
      3'd0:    rd_data = mode_q;
      3'd1:    rd_data = {4'b0000, flag_q, run_q};
      3'd2:    rd_data = lo_q[0];
      3'd3:    rd_data = hi_q[0];
      3'd4:    rd_data = lo_q[1];
      3'd5:    rd_data = hi_q[1];
      default: rd_data = 8'h00;
    endcase
  end

  assign ovf_flag   = flag_q;
  assign baud_pulse = baud_q;
endmodule

module twin_timer_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_sel,
  input logic [7:0]  wr_data,
  input logic        ack0,
  input logic [1:0]  ovf_flag,
  input logic        baud_pulse,
  input logic [1:0]  ch0_md,
  input logic [1:0]  ch1_md,
  input logic [1:0]  run,
  input logic [15:0] lo_all,
  input logic [15:0] hi_all
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run == 2'b00 && !(wr_en && (wr_sel == 3'd2 || wr_sel == 3'd3)))
    |=> $stable({hi_all[7:0], lo_all[7:0]}));

  // R13
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd2) |=> (lo_all[7:0] == $past(wr_data)));

  // R12
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack0 && !run[0] && !(wr_en && wr_sel == 3'd1)) |=> !ovf_flag[0]);

  // R11
  baud_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_pulse |=> !baud_pulse);

  // R7
  reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_pulse && ch1_md == 2'b10 && !$past(wr_en)) |-> (lo_all[15:8] == hi_all[15:8]));

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_pulse && ch0_md != 2'b11 && $past(ch0_md) != 2'b11) |-> ovf_flag[1]);
endmodule

bind twin_timer_unit twin_timer_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ack0(flag_ack[0]), .ovf_flag(ovf_flag), .baud_pulse(baud_pulse),
  .ch0_md(mode_q[1:0]), .ch1_md(mode_q[5:4]), .run(run_q),
  .lo_all(lo_q), .hi_all(hi_q)
);

// File: tb/twin_timer_unit_bench.sv
`timescale 1ns/1ps
module twin_timer_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic [1:0] cnt_pin = '0;
  logic [1:0] gate_pin = '0;
  logic [1:0] flag_ack = '0;
  logic [1:0] ovf_flag;
  logic       baud_pulse;

  int checks = 0;
  int errors = 0;
  int rises = 0;
  int hi_cyc = 0;
  logic baud_prev = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] a;
    logic [7:0] e;
    string      tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  twin_timer_unit u_twin_timer_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .flag_ack(flag_ack), .ovf_flag(ovf_flag), .baud_pulse(baud_pulse)
  );

  always @(negedge clk) begin
    item_t it;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      checks++;
      if (rd_data !== it.e) begin
        errors++;
        $display("FAIL %s: reg %0d actual %02h expected %02h", it.tag, it.a, rd_data, it.e);
      end
    end
    if (baud_pulse) hi_cyc++;
    if (baud_pulse && !baud_prev) rises++;
    baud_prev <= baud_pulse;
  end

  task automatic chk(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk); #1;
    rd_sel = a;
    it.a = a; it.e = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic chk_num(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic win(input logic [7:0] v, input int k);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (12 * k - 1) @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic find_phase();
    logic [7:0] prev;
    rd_sel = 3'd2;
    @(negedge clk);
    prev = rd_data;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (rd_data != prev) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) chk(3'(a), 8'h00, "R1 reset");
    chk_num(ovf_flag, 0, "R1 flags");
    chk_num(baud_pulse, 0, "R1 baud");

    // R13 readback
    wr(3'd0, 8'h01);
    chk(3'd0, 8'h01, "R13 config readback");

    // R2 tick counting, 16-bit
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    win(8'h01, 5);
    chk(3'd2, 8'h05, "R2 five ticks low");
    chk(3'd3, 8'h00, "R2 five ticks high");
    wr(3'd2, 8'hFE);
    win(8'h01, 3);
    chk(3'd2, 8'h01, "R2 carry low");
    chk(3'd3, 8'h01, "R2 carry high");

    // R4 gate
    wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    gate_pin = 2'b00;
    win(8'h01, 3);
    chk(3'd2, 8'h00, "R4 gate low blocks");
    gate_pin = 2'b01;
    win(8'h01, 3);
    chk(3'd2, 8'h03, "R4 gate high counts");
    gate_pin = 2'b00;

    // R3 external edges
    wr(3'd0, 8'h05); wr(3'd2, 8'h00);
    wr(3'd1, 8'h01);
    repeat (5) begin
      cnt_pin[0] = 1'b1; repeat (30) @(negedge clk);
      cnt_pin[0] = 1'b0; repeat (30) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    wr(3'd1, 8'h00);
    chk(3'd2, 8'h05, "R3 five pulses");

    // R5 13-bit mode
    wr(3'd0, 8'h00); wr(3'd2, 8'h1F); wr(3'd3, 8'h05);
    win(8'h01, 1);
    chk(3'd2, 8'h00, "R5 prescale carry low");
    chk(3'd3, 8'h06, "R5 prescale carry high");
    chk(3'd1, 8'h00, "R5 no flag");
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    win(8'h01, 2);
    chk(3'd2, 8'hE0, "R5 wrap keeps upper bits");
    chk(3'd3, 8'h00, "R5 wrap high");
    chk(3'd1, 8'h04, "R5 flag set");
    chk_num(ovf_flag, 1, "R5 flag port");

    // R12 write-one clears
    wr(3'd1, 8'h04);
    chk(3'd1, 8'h00, "R12 write clear");

    // R13 write versus increment in one cycle
    wr(3'd0, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd1, 8'h01);
    find_phase();
    repeat (10) @(negedge clk);
    wr(3'd2, 8'h50);
    wr(3'd1, 8'h00);
    chk(3'd2, 8'h50, "R13 write overrides tick");
    chk(3'd3, 8'h00, "R13 high untouched");

    // R12 hardware set beats acknowledge
    wr(3'd1, 8'h01);
    find_phase();
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'hFF);
    repeat (7) @(negedge clk);
    flag_ack = 2'b01;
    @(negedge clk);
    flag_ack = 2'b00;
    wr(3'd1, 8'h00);
    chk(3'd1, 8'h04, "R12 set wins over ack");
    @(negedge clk); flag_ack = 2'b01;
    @(negedge clk); flag_ack = 2'b00;
    chk(3'd1, 8'h00, "R12 ack clears");

    // R6 ch1 16-bit wrap, R11 pulse
    wr(3'd0, 8'h10); wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
    b0 = rises;
    win(8'h02, 2);
    chk(3'd4, 8'h00, "R6 wrap low");
    chk(3'd5, 8'h00, "R6 wrap high");
    chk(3'd1, 8'h08, "R6 flag");
    chk_num(rises, b0 + 1, "R11 one pulse");
    chk_num(hi_cyc, rises, "R11 single cycle");
    wr(3'd1, 8'h08);

    // R7 ch1 reload
    wr(3'd0, 8'h20); wr(3'd5, 8'hF0); wr(3'd4, 8'hFE);
    b0 = rises;
    win(8'h02, 3);
    chk(3'd4, 8'hF1, "R7 reload low");
    chk(3'd5, 8'hF0, "R7 high kept");
    chk(3'd1, 8'h08, "R7 flag");
    chk_num(rises, b0 + 1, "R11 reload pulse");
    wr(3'd1, 8'h08);

    // R9 ch1 frozen
    wr(3'd0, 8'h30); wr(3'd4, 8'h12); wr(3'd5, 8'h34);
    b0 = rises;
    win(8'h02, 3);
    chk(3'd4, 8'h12, "R9 hold low");
    chk(3'd5, 8'h34, "R9 hold high");
    chk(3'd1, 8'h00, "R9 no flag");
    chk_num(rises, b0, "R9 no pulse");

    // R8 split ch0
    wr(3'd0, 8'h33); wr(3'd2, 8'hFE); wr(3'd3, 8'hFD);
    win(8'h03, 2);
    chk(3'd2, 8'h00, "R8 split low wrap");
    chk(3'd3, 8'hFF, "R8 split high");
    chk(3'd1, 8'h04, "R8 flag0 only");
    win(8'h02, 1);
    chk(3'd3, 8'h00, "R8 split high wrap");
    chk(3'd2, 8'h00, "R8 low stopped");
    chk(3'd1, 8'h0C, "R8 flag1 from high");
    wr(3'd1, 8'h0C);

    // R10 ch1 runs during split
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    b0 = rises;
    wr(3'd0, 8'h13);
    repeat (30) @(negedge clk);
    wr(3'd0, 8'h33);
    chk(3'd5, 8'h00, "R10 ch1 wrapped");
    chk(3'd1, 8'h00, "R10 no flag1");
    chk_num(rises, b0 + 1, "R10 pulse");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule